// File: doc/BRIEF.md
# Local Interrupt Concentrator

This block collects up to 64 interrupt request lines from nearby peripherals and keeps a pending image of them in a status register placed close to the core. A service routine can read every cause in a couple of register accesses instead of polling each peripheral. Each source is configured for one of two modes. In pulse mode a rising edge sets a pending bit that stays set until software clears it. In level mode the bit follows the line.

Sources are gathered in fixed groups of consecutive lines. Each group drives one registered request output toward the main interrupt controller. That output is the OR of the group's pending bits that are enabled. Arbitration between requests and vectoring are left to the downstream controller.

The register port is word-wide and uses a synchronous read. The address is `{select, word}`. The select field is two bits and sits above the word index: 0 is mode, 1 is enable and 2 is status. Select 3 is unmapped.

Top module: `lic_concentrator`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), mode, enable and status are all zero, `irq_out` is zero and `reg_rdata` is zero. Every source is therefore in level mode and disabled.
- R2: For a source whose mode bit is 0 (level), the status bit equals the value of `src` sampled at the previous clock edge.
- R3: For a source whose mode bit is 1 (pulse), a 0-to-1 change of `src` between two consecutive clock samples sets its status bit at the second edge. The bit then stays set after the input falls.
- R4: Writing a status word sets a clear mask from `reg_wdata`. A 1 in bit b clears pending source `32*word+b` at that edge. Bits written as 0 leave their sources untouched.
- R5: If a rising edge of a pulse-mode source and a clear of the same bit occur at the same clock edge, the status bit ends set.
- R6: In level mode a status clear write has no effect. The bit keeps following the input.
- R7: `irq_out[g]` equals, one clock after the status, the OR over sources 16g to 16g+15 of status AND enable.
- R8: Address bits [2:1] select the register: 0 is mode, 1 is enable, 2 is status, and 3 reads as zero. Address bit 0 selects word 0 (sources 0..31) or word 1 (sources 32..63). `reg_rdata` is loaded at the edge where `reg_rd` is high and holds otherwise.
- R9: A write to mode or enable replaces the addressed 32-bit word. The new value reads back, and the other word is unchanged.
- R10: A pulse-mode source held high after its bit is cleared does not set the bit again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 64 | Interrupt source lines, synchronous to clk |
| reg_addr | input | 3 | Register address {select[1:0], word} |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; for status it is the clear mask |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 4 | Group request lines toward the main controller |

## Verification
The checker watches the following on every cycle:
- level bits track the previous input sample;
- pulse bits are sticky unless cleared;
- a rising edge in pulse mode always lands in the status;
- each group output matches the enabled pending bits of the cycle before.

Some behaviour only the bench scenarios can show, because it depends on what software sees through the register port:
- address decoding and word placement of the readback;
- the edge-versus-clear collision;
- a held-high line not re-arming after a clear;
- long random mixes of mode changes, clears and reads compared against a bench model.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } lic_sel_e;
endpackage

// File: rtl/lic_cfg_regs.sv
module lic_cfg_regs #(
  parameter int N_SRC  = 64,
  parameter int DW     = 32,
  parameter int WORD_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word_idx,
  input  logic [DW-1:0]     wdata,
  output logic [N_SRC-1:0]  mode_q,
  output logic [N_SRC-1:0]  en_q
);
  localparam int N_WORD = N_SRC / DW;

  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[w*DW +: DW] <= '0;
        en_q[w*DW +: DW]   <= '0;
      end else begin
        if (wr_mode && word_idx == WORD_W'(w)) mode_q[w*DW +: DW] <= wdata;
        if (wr_en && word_idx == WORD_W'(w))   en_q[w*DW +: DW]   <= wdata;
      end
    end
  end
endmodule

// File: rtl/lic_status.sv
module lic_status #(
  parameter int N_SRC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] mode,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] stat_q
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] stat_d;

  always_comb begin
    rise   = src & ~src_q;
    // pulse bits: sticky, clear loses against a fresh edge; level bits: follow input
    stat_d = (mode & ((stat_q & ~clr_mask) | rise)) | (~mode & src);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      stat_q <= '0;
    end else begin
      src_q  <= src;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/lic_group_or.sv
module lic_group_or #(
  parameter int N_SRC  = 64,
  parameter int GRP_SZ = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SRC-1:0]         stat,
  input  logic [N_SRC-1:0]         en,
  output logic [N_SRC/GRP_SZ-1:0]  irq_q
);
  localparam int N_GRP = N_SRC / GRP_SZ;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= |(stat[g*GRP_SZ +: GRP_SZ] & en[g*GRP_SZ +: GRP_SZ]);
    end
  end
endmodule

// File: rtl/lic_concentrator.sv
module lic_concentrator #(
  parameter int N_SRC  = 64,
  parameter int GRP_SZ = 16,
  parameter int DW     = 32,
  localparam int N_GRP  = N_SRC / GRP_SZ,
  localparam int N_WORD = N_SRC / DW,
  localparam int WORD_W = (N_WORD > 1) ? $clog2(N_WORD) : 1,
  localparam int ADDR_W = 2 + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  output logic [N_GRP-1:0]  irq_out
);
  import lic_pkg::*;

  lic_sel_e          sel;
  logic [WORD_W-1:0] word_idx;
  logic [N_SRC-1:0]  mode_q;
  logic [N_SRC-1:0]  en_q;
  logic [N_SRC-1:0]  stat_q;
  logic [N_SRC-1:0]  clr_mask;
  logic [DW-1:0]     rd_word;

  assign sel      = lic_sel_e'(reg_addr[ADDR_W-1 -: 2]);
  assign word_idx = reg_addr[WORD_W-1:0];

  for (genvar w = 0; w < N_WORD; w++) begin : g_clr
    assign clr_mask[w*DW +: DW] =
      (reg_wr && sel == SEL_STAT && word_idx == WORD_W'(w)) ? reg_wdata : '0;
  end

  lic_cfg_regs #(.N_SRC(N_SRC), .DW(DW), .WORD_W(WORD_W)) i_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_mode  (reg_wr && sel == SEL_MODE),
    .wr_en    (reg_wr && sel == SEL_EN),
    .word_idx (word_idx),
    .wdata    (reg_wdata),
    .mode_q   (mode_q),
    .en_q     (en_q)
  );

  lic_status #(.N_SRC(N_SRC)) i_stat (
    .clk      (clk),
    .rst      (rst),
    .src      (src),
    .mode     (mode_q),
    .clr_mask (clr_mask),
    .stat_q   (stat_q)
  );

  lic_group_or #(.N_SRC(N_SRC), .GRP_SZ(GRP_SZ)) i_grp (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat_q),
    .en    (en_q),
    .irq_q (irq_out)
  );

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < N_WORD; w++) begin
      if (word_idx == WORD_W'(w)) begin
        case (sel)
          SEL_MODE: rd_word = mode_q[w*DW +: DW];
          SEL_EN:   rd_word = en_q[w*DW +: DW];
          SEL_STAT: rd_word = stat_q[w*DW +: DW];
          default:  rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/lic_concentrator_chk.sv
module lic_concentrator_chk #(
  parameter int N_SRC  = 64,
  parameter int GRP_SZ = 16,
  parameter int DW     = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_SRC-1:0]        src,
  input logic [N_SRC/GRP_SZ-1:0] irq_out,
  input logic [DW-1:0]           reg_rdata,
  input logic [N_SRC-1:0]        mode,
  input logic [N_SRC-1:0]        en,
  input logic [N_SRC-1:0]        stat,
  input logic [N_SRC-1:0]        clr
);
  localparam int N_GRP = N_SRC / GRP_SZ;
  logic [1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst)                 seen_q <= 2'd0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && reg_rdata == '0 && stat == '0 && mode == '0 && en == '0));

  // R2
  level_track_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd0) |-> ((stat ^ $past(src)) & ~$past(mode)) == '0);

  // R3
  pulse_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd0) |-> ($past(stat & mode & ~clr) & ~stat) == '0);

  // R5
  pulse_set_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 2'd2) |-> ($past(src & mode) & ~$past(src, 2) & ~stat) == '0);

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    // R7
    group_req_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q != 2'd0) |->
        irq_out[g] == |$past(stat[g*GRP_SZ +: GRP_SZ] & en[g*GRP_SZ +: GRP_SZ]));
  end
endmodule

bind lic_concentrator lic_concentrator_chk #(.N_SRC(N_SRC), .GRP_SZ(GRP_SZ), .DW(DW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .src       (src),
  .irq_out   (irq_out),
  .reg_rdata (reg_rdata),
  .mode      (mode_q),
  .en        (en_q),
  .stat      (stat_q),
  .clr       (clr_mask)
);

// File: tb/test_lic_concentrator.sv
`timescale 1ns/1ps
module test_lic_concentrator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model state
  logic [63:0] m_mode, m_en, m_stat, m_prev;
  logic [3:0]  m_irq;
  logic [31:0] m_rdata;

  lic_concentrator i_lic_concentrator (
    .clk(clk), .rst(rst), .src(src), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] pick(input logic [63:0] v, input logic w);
    return w ? v[63:32] : v[31:0];
  endfunction

  always @(posedge clk) begin
    logic [63:0] clrm, nstat;
    if (rst) begin
      m_mode = '0; m_en = '0; m_stat = '0; m_prev = '0; m_irq = '0; m_rdata = '0;
    end else begin
      clrm = '0;
      if (reg_wr && reg_addr[2:1] == 2'd2) clrm[reg_addr[0]*32 +: 32] = reg_wdata;
      for (int g = 0; g < 4; g++) m_irq[g] = |(m_stat[g*16 +: 16] & m_en[g*16 +: 16]);
      if (reg_rd) begin
        case (reg_addr[2:1])
          2'd0: m_rdata = pick(m_mode, reg_addr[0]);
          2'd1: m_rdata = pick(m_en, reg_addr[0]);
          2'd2: m_rdata = pick(m_stat, reg_addr[0]);
          default: m_rdata = '0;
        endcase
      end
      nstat  = (m_mode & ((m_stat & ~clrm) | (src & ~m_prev))) | (~m_mode & src);
      m_stat = nstat;
      m_prev = src;
      if (reg_wr && reg_addr[2:1] == 2'd0) m_mode[reg_addr[0]*32 +: 32] = reg_wdata;
      if (reg_wr && reg_addr[2:1] == 2'd1) m_en[reg_addr[0]*32 +: 32]   = reg_wdata;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic w, input logic [31:0] d);
    reg_addr = {s, w}; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] s, input logic w, output logic [31:0] d);
    reg_addr = {s, w}; reg_rd = 1'b1;
    cyc();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1: reset state
    check("R1 irq_out", 64'(irq_out), 0);
    check("R1 rdata", 64'(reg_rdata), 0);
    rd(2'd0, 1'b0, d); check("R1 mode w0", 64'(d), 0);
    rd(2'd1, 1'b1, d); check("R1 enable w1", 64'(d), 0);
    rd(2'd2, 1'b0, d); check("R1 status w0", 64'(d), 0);

    // R9 / R8: configuration words and decoding
    wr(2'd0, 1'b0, 32'h0000_FFFF);
    wr(2'd1, 1'b0, 32'hFFFF_FFFF);
    wr(2'd1, 1'b1, 32'h0000_0100);
    rd(2'd0, 1'b0, d); check("R9 mode w0", 64'(d), 64'h0000_FFFF);
    rd(2'd0, 1'b1, d); check("R9 mode w1 untouched", 64'(d), 0);
    rd(2'd1, 1'b1, d); check("R9 enable w1", 64'(d), 64'h0000_0100);
    rd(2'd3, 1'b0, d); check("R8 unmapped", 64'(d), 0);

    // R3: rising edge sets sticky pending
    src[3] = 1'b1; cyc();
    rd(2'd2, 1'b0, d); check("R3 set", 64'(d), 64'h8);
    check("R7 group0 req", 64'(irq_out), 64'h1);
    src[3] = 1'b0; cyc(); cyc();
    rd(2'd2, 1'b0, d); check("R3 sticky", 64'(d), 64'h8);

    // R4: write-one-to-clear
    wr(2'd2, 1'b0, 32'h0000_0028);
    rd(2'd2, 1'b0, d); check("R4 cleared", 64'(d), 0);
    check("R7 group0 drop", 64'(irq_out), 0);

    // R10: held-high line does not re-arm
    src[4] = 1'b1; cyc();
    wr(2'd2, 1'b0, 32'h0000_0010);
    cyc(); cyc();
    rd(2'd2, 1'b0, d); check("R10 no rearm", 64'(d), 0);
    src[4] = 1'b0; cyc();

    // R5: edge and clear at the same edge
    src[6] = 1'b1; cyc();
    src[6] = 1'b0; cyc();
    src[6] = 1'b1;
    wr(2'd2, 1'b0, 32'h0000_0040);
    rd(2'd2, 1'b0, d); check("R5 edge wins", 64'(d), 64'h40);

    // R2: level follows input
    src[20] = 1'b1; cyc();
    rd(2'd2, 1'b0, d); check("R2 level high", 64'(d), 64'h10_0040);
    check("R7 group1 req", 64'(irq_out), 64'h3);
    src[20] = 1'b0; cyc();
    rd(2'd2, 1'b0, d); check("R2 level low", 64'(d), 64'h40);

    // R6: clear ignored in level mode
    src[20] = 1'b1; cyc();
    wr(2'd2, 1'b0, 32'h0010_0000);
    rd(2'd2, 1'b0, d); check("R6 clear ignored", 64'(d), 64'h10_0040);

    // R8: upper word placement
    src[40] = 1'b1; cyc();
    rd(2'd2, 1'b1, d); check("R8 status w1", 64'(d), 64'h100);
    check("R7 group2 req", 64'(irq_out), 64'h7);

    // R7: enable gating
    wr(2'd1, 1'b0, 32'h0);
    wr(2'd1, 1'b1, 32'h0);
    cyc(); cyc();
    check("R7 gated", 64'(irq_out), 0);
    wr(2'd1, 1'b0, 32'h0000_0040);
    cyc(); cyc();
    check("R7 single group", 64'(irq_out), 64'h1);

    // random mix against the bench model
    rst = 1'b1; src = '0; cyc(); cyc();
    rst = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      cyc();
      check("R7 random irq_out", 64'(irq_out), 64'(m_irq));
      check("R2 R3 R4 R8 random rdata", 64'(reg_rdata), 64'(m_rdata));
      src       = src ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      reg_addr  = 3'($urandom);
      reg_wdata = $urandom;
      reg_wr    = ($urandom % 5) == 0;
      reg_rd    = ($urandom % 3) == 0;
    end
    reg_wr = 1'b0; reg_rd = 1'b0;
    cyc();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule